// File: doc/BRIEF.md
# Step/Direction Microstep Sequencer

This block converts a stream of step pulses and a direction level into write cycles on the 8-bit parallel port of a two-channel sign/magnitude current-reference converter. A wrapping position counter moves by a selectable stride on every step, up or down. Its value picks a point on one electrical cycle of 64 microsteps. Channel 1 receives the sine word of that point and channel 2 the cosine word. Each word holds a sign bit above a 7-bit magnitude.

The converter port accepts only one channel register per write strobe. The block therefore offers two programming modes. In double-pulse mode, every step loads channel 1 and then channel 2 with the shortest gap between the two strobes. In single-pulse mode, every step loads a single channel and the channels take turns, so that each pair of neighbouring writes defines an intermediate position. The stride selects the resolution: 16 gives full or wave stepping, 8 gives half steps, 4 quarter steps, and 1 the finest microsteps. A step that arrives while a write sequence is running is held in a one-entry queue.

Top module: `ustep_seq`

## Requirements
- R1: While reset is asserted, and whenever `busy_o` is low, the bus is idle: `cs_n_o` is 1 and `wr_o` is 0. In the first sample after reset is released, `busy_o` is already 1. A double-pulse update of position 0 follows without any step: channel 1 receives 0x00 and then channel 2 receives 0x7F.
- R2: A data word is {sign, magnitude[6:0]}, with sign 1 meaning negative. For position p (0..63) and angle a = 2*pi*p/64, the channel 1 word has magnitude round(127*|sin a|) and sign 1 when p >= 32. The channel 2 word has magnitude round(127*|cos a|) and sign 1 when (p+16) mod 64 >= 32. For example, channel 2 at p=16 is 0x80.
- R3: A step moves the position by `stride_i`, counting up when `dir_i` is 1 and down when it is 0, modulo 64 in both directions.
- R4: Each write keeps `cs_n_o` low through the whole cycle. `a0_o` is 0 to select channel 1 and 1 to select channel 2. `a0_o` and `data_o` are valid one clock before `wr_o` rises and stay unchanged for one clock after it falls. `wr_o` is high for exactly one clock.
- R5: With `single_i` at 0, a step produces two writes, channel 1 first and then channel 2. The two strobes rise 3 clocks apart.
- R6: With `single_i` at 1, a step produces exactly one write. The channel alternates between steps in single-pulse mode. The first single-pulse write after reset or after any double-pulse step goes to channel 1.
- R7: A step sampled while `busy_o` is low raises `busy_o` on the next clock, and its first strobe rises 2 clocks after the step is sampled.
- R8: A step sampled while `busy_o` is high is queued. It is applied when the running sequence ends, with `dir_i` as it was on arrival, and with `stride_i` and `single_i` as they are when it is applied. Further steps that arrive while the queue is full are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | One step for each clock in which it is high |
| dir_i | input | 1 | 1 counts up, 0 counts down |
| stride_i | input | 6 | Position increment for each step |
| single_i | input | 1 | 1 selects single-pulse, 0 selects double-pulse programming |
| busy_o | output | 1 | A write sequence or the initial update is pending or running |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| a0_o | output | 1 | Channel address: 0 selects channel 1, 1 selects channel 2 |
| wr_o | output | 1 | Write strobe; the converter latches on its rising edge |
| data_o | output | 8 | Sign/magnitude word |

## Verification
When a step is sampled at an idle edge, the strobe for the first write rises 2 clocks later. In double-pulse mode the second strobe follows 3 clocks after the first, and a queued step's first strobe comes 2 clocks after the preceding sequence ends. A bus monitor in the bench records the clock count and the bus contents at each strobe rise. The bench compares these records with the step's issue cycle plus those offsets, and compares the words with values computed from trigonometry on a model position. The monitor checks setup and hold one clock either side of each strobe, and the bench waits for `busy_o` to fall before it issues the next directed or random step.

// File: rtl/ustep_pkg.sv
// Shared constants, types and table arithmetic for the microstep sequencer.
// Assumes a 64-entry electrical cycle (POS_W = 6), so a quarter wave has 16 points plus the endpoint.
package ustep_pkg;
    localparam int POS_W  = 6;
    localparam int WORD_W = 8;
    localparam int QTR_W  = POS_W - 2;
    localparam int QTR    = 1 << QTR_W;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic [1:0] {B_IDLE, B_SET, B_STB, B_HOLD} bus_st_t;

    // Quarter-wave magnitude round(127*sin(k*pi/32)), k = 0..16
    function automatic logic [WORD_W-2:0] quarter_mag(input logic [QTR_W:0] k);
        case (k)
            5'd0:  quarter_mag = 7'd0;
            5'd1:  quarter_mag = 7'd12;
            5'd2:  quarter_mag = 7'd25;
            5'd3:  quarter_mag = 7'd37;
            5'd4:  quarter_mag = 7'd49;
            5'd5:  quarter_mag = 7'd60;
            5'd6:  quarter_mag = 7'd71;
            5'd7:  quarter_mag = 7'd81;
            5'd8:  quarter_mag = 7'd90;
            5'd9:  quarter_mag = 7'd98;
            5'd10: quarter_mag = 7'd106;
            5'd11: quarter_mag = 7'd112;
            5'd12: quarter_mag = 7'd117;
            5'd13: quarter_mag = 7'd122;
            5'd14: quarter_mag = 7'd125;
            5'd15: quarter_mag = 7'd126;
            5'd16: quarter_mag = 7'd127;
            default: quarter_mag = 7'd0;
        endcase
    endfunction

    // Sign/magnitude sine word of a position: quadrant folds the quarter table
    function automatic word_t sine_word(input pos_t p);
        logic [QTR_W-1:0] idx;
        logic [QTR_W:0]   k;
        idx = p[QTR_W-1:0];
        if (p[POS_W-2])
            k = (QTR_W+1)'(QTR) - {1'b0, idx};
        else
            k = {1'b0, idx};
        return {p[POS_W-1], quarter_mag(k)};
    endfunction
endpackage

// File: rtl/ustep_lut.sv
// Quadrature lookup: sine word for channel 1 and cosine word for channel 2 of one position.
// Purely combinational; assumes the position is held stable during a write sequence.
module ustep_lut
    import ustep_pkg::*;
(
    input  pos_t  pos_i,
    output word_t ch1_o,
    output word_t ch2_o
);
    // Cosine is the sine a quarter cycle ahead
    always_comb begin
        ch1_o = sine_word(pos_i);
        ch2_o = sine_word(pos_i + pos_t'(QTR));
    end
endmodule

// File: rtl/ustep_pos.sv
// Position counter with a one-entry step queue and the post-reset update request.
// Assumes free_i is high in any cycle where the bus engine can accept a new sequence.
module ustep_pos
    import ustep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic dir_i,
    input  pos_t stride_i,
    input  logic free_i,
    output logic go_o,
    output logic init_o,
    output pos_t pos_o
);
    logic init_q, pend_q, pdir_q;
    pos_t pos_q;
    logic take_pend, take_step;

    // Decide which request, if any, starts a sequence this cycle
    always_comb begin
        take_pend = free_i && !init_q && pend_q;
        take_step = free_i && !init_q && !pend_q && step_i;
        go_o      = free_i && (init_q || pend_q || step_i);
        init_o    = init_q;
        pos_o     = pos_q;
    end

    // Advance the position and manage the queue slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b1;
            pend_q <= 1'b0;
            pdir_q <= 1'b0;
            pos_q  <= '0;
        end else if (free_i) begin
            init_q <= 1'b0;
            if (init_q || pend_q) begin
                pend_q <= step_i;
                pdir_q <= dir_i;
            end else begin
                pend_q <= 1'b0;
            end
            if (take_pend)
                pos_q <= pdir_q ? pos_q + stride_i : pos_q - stride_i;
            else if (take_step)
                pos_q <= dir_i ? pos_q + stride_i : pos_q - stride_i;
        end else if (step_i && !pend_q) begin
            pend_q <= 1'b1;
            pdir_q <= dir_i;
        end
    end
endmodule

// File: rtl/ustep_bus.sv
// Bus engine: each write is setup, strobe and hold clocks; double mode chains channel 1 then 2.
// Assumes go_i is only acted on while free_o is high.
module ustep_bus
    import ustep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic force_dbl_i,
    input  logic single_i,
    output logic free_o,
    output logic busy_o,
    output logic cs_n_o,
    output logic wr_o,
    output logic ch_o
);
    bus_st_t st_q;
    logic    ch_q, dbl_q, alt_q;
    logic    last, alt_nx, start_dbl;

    // Sequence end detection and next single-pulse channel
    always_comb begin
        last      = (st_q == B_HOLD) && !(dbl_q && !ch_q);
        free_o    = (st_q == B_IDLE) || last;
        alt_nx    = last ? (dbl_q ? 1'b0 : ~ch_q) : alt_q;
        start_dbl = force_dbl_i || !single_i;
        busy_o    = (st_q != B_IDLE);
        cs_n_o    = (st_q == B_IDLE);
        wr_o      = (st_q == B_STB);
        ch_o      = ch_q;
    end

    // Step through the write phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= B_IDLE;
            ch_q  <= 1'b0;
            dbl_q <= 1'b1;
            alt_q <= 1'b0;
        end else begin
            alt_q <= alt_nx;
            if (free_o && go_i) begin
                st_q  <= B_SET;
                dbl_q <= start_dbl;
                ch_q  <= start_dbl ? 1'b0 : alt_nx;
            end else if (free_o) begin
                st_q <= B_IDLE;
            end else begin
                case (st_q)
                    B_SET:   st_q <= B_STB;
                    B_STB:   st_q <= B_HOLD;
                    B_HOLD: begin
                        st_q <= B_SET;
                        ch_q <= 1'b1;
                    end
                    default: st_q <= B_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ustep_seq.sv
// Top level: step/direction input to two-channel sign/magnitude converter writes.
// Assumes step_i is synchronous to clk; every high clock counts as one step.
module ustep_seq
    import ustep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              dir_i,
    input  logic [POS_W-1:0]  stride_i,
    input  logic              single_i,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic              a0_o,
    output logic              wr_o,
    output logic [WORD_W-1:0] data_o
);
    logic  free, go, init, bus_busy, ch;
    pos_t  pos;
    word_t w1, w2;

    ustep_pos u_pos (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
        .stride_i(stride_i), .free_i(free), .go_o(go), .init_o(init), .pos_o(pos)
    );

    ustep_bus u_bus (
        .clk(clk), .rst_n(rst_n), .go_i(go), .force_dbl_i(init), .single_i(single_i),
        .free_o(free), .busy_o(bus_busy), .cs_n_o(cs_n_o), .wr_o(wr_o), .ch_o(ch)
    );

    ustep_lut u_lut (.pos_i(pos), .ch1_o(w1), .ch2_o(w2));

    // Route the addressed channel's word onto the bus
    always_comb begin
        a0_o   = ch;
        data_o = ch ? w2 : w1;
        busy_o = bus_busy || init;
    end
endmodule

// File: rtl/ustep_seq_chk.sv
// Port-level protocol checker for ustep_seq, attached by bind.
module ustep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_i,
    input logic       busy_o,
    input logic       cs_n_o,
    input logic       a0_o,
    input logic       wr_o,
    input logic [7:0] data_o
);
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !wr_o));
    assert_strobe_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> !cs_n_o);
    assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_o) |-> ($stable(data_o) && $stable(a0_o) && !$past(cs_n_o)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> ($stable(data_o) && $stable(a0_o) && !cs_n_o));
    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy_o) |=> (busy_o && !cs_n_o && !wr_o) ##1 wr_o);
endmodule

bind ustep_seq ustep_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .busy_o(busy_o),
    .cs_n_o(cs_n_o), .a0_o(a0_o), .wr_o(wr_o), .data_o(data_o)
);

// File: tb/ustep_seq_tb.sv
`timescale 1ns/1ps
module ustep_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0, dir = 1'b1, single = 1'b0;
    logic [5:0] stride = 6'd1;
    logic       busy, cs_n, a0, wr;
    logic [7:0] data;

    int total = 0, bad = 0, cyc = 0, wn = 0;
    int pos_m = 0, alt_m = 0;
    int         log_a0 [0:1023];
    logic [7:0] log_d  [0:1023];
    int         log_t  [0:1023];
    logic       p_wr = 1'b0, p_cs = 1'b1, p_a0 = 1'b0;
    logic [7:0] p_d = 8'h00;
    int         rise_t = 0;

    ustep_seq dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step), .dir_i(dir), .stride_i(stride),
        .single_i(single), .busy_o(busy), .cs_n_o(cs_n), .a0_o(a0), .wr_o(wr), .data_o(data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
        end
    endtask

    // Expected word from the requirement R2 formula
    function automatic int exp_word(input int ch, input int p);
        int  q;
        real s;
        int  mag;
        q   = (p + 16 * ch) % 64;
        s   = $sin(2.0 * 3.14159265358979 * q / 64.0);
        if (s < 0.0) s = -s;
        mag = $rtoi(s * 127.0 + 0.5);
        return ((q >= 32) ? 128 : 0) + mag;
    endfunction

    // Bus monitor: logs writes and checks setup/hold/pulse width (R4)
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr && !p_wr) begin
                chk(p_a0 == a0 && p_d == data, "R4 setup stable", int'(data), int'(p_d));
                chk(!p_cs && !cs_n, "R4 cs framing at rise", int'(cs_n), 0);
                if (wn < 1024) begin
                    log_a0[wn] = int'(a0);
                    log_d[wn]  = data;
                    log_t[wn]  = cyc;
                end
                wn++;
                rise_t = cyc;
            end
            if (!wr && p_wr) begin
                chk(p_a0 == a0 && p_d == data && !cs_n, "R4 hold stable", int'(data), int'(p_d));
                chk(cyc == rise_t + 1, "R4 strobe width", cyc - rise_t, 1);
            end
        end
        p_wr = wr; p_cs = cs_n; p_a0 = a0; p_d = data;
    end

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(n < 300, "R7 busy release", n, 0);
    endtask

    task automatic check_seq(input int w0, input int c0, input int sm);
        if (sm == 0) begin
            chk(wn - w0 == 2, "R5 write count", wn - w0, 2);
            chk(log_a0[w0] == 0 && int'(log_d[w0]) == exp_word(0, pos_m), "R2 R5 ch1 word",
                int'(log_d[w0]), exp_word(0, pos_m));
            chk(log_a0[w0+1] == 1 && int'(log_d[w0+1]) == exp_word(1, pos_m), "R2 R5 ch2 word",
                int'(log_d[w0+1]), exp_word(1, pos_m));
            chk(log_t[w0] == c0 + 2, "R7 first strobe", log_t[w0] - c0, 2);
            chk(log_t[w0+1] == c0 + 5, "R5 strobe gap", log_t[w0+1] - c0, 5);
            alt_m = 0;
        end else begin
            chk(wn - w0 == 1, "R6 write count", wn - w0, 1);
            chk(log_a0[w0] == alt_m, "R6 channel alternation", log_a0[w0], alt_m);
            chk(int'(log_d[w0]) == exp_word(alt_m, pos_m), "R2 R3 single word",
                int'(log_d[w0]), exp_word(alt_m, pos_m));
            chk(log_t[w0] == c0 + 2, "R7 first strobe", log_t[w0] - c0, 2);
            alt_m = 1 - alt_m;
        end
    endtask

    task automatic do_step(input bit d, input int s, input bit sm);
        int w0, c0;
        w0 = wn; c0 = cyc;
        step = 1'b1; dir = d; stride = 6'(s); single = sm;
        @(negedge clk);
        step = 1'b0;
        chk(busy == 1'b1, "R7 busy after step", int'(busy), 1);
        wait_idle();
        pos_m = d ? (pos_m + s) % 64 : (pos_m + 64 - s) % 64;
        check_seq(w0, c0, int'(sm));
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0, c0, sel, s;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && wr == 1'b0, "R1 bus idle in reset", int'(cs_n), 1);
        // R1: release reset, expect the initial double update of position 0
        c0 = cyc; w0 = wn;
        rst_n = 1'b1;
        #0;
        chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
        @(negedge clk);
        wait_idle();
        chk(wn - w0 == 2 && int'(log_d[w0]) == 8'h00 && int'(log_d[w0+1]) == 8'h7F,
            "R1 initial update", int'(log_d[w0+1]), 8'h7F);
        chk(log_t[w0] == c0 + 2, "R1 initial timing", log_t[w0] - c0, 2);
        chk(cs_n == 1'b1 && wr == 1'b0, "R1 idle bus", int'(cs_n), 1);
        // R3: wrap down then up
        do_step(1'b0, 1, 1'b0);
        do_step(1'b1, 1, 1'b0);
        // R2: wave stride hits the zero crossings (0x80 words)
        do_step(1'b1, 16, 1'b0);
        do_step(1'b1, 16, 1'b0);
        do_step(1'b1, 16, 1'b0);
        do_step(1'b1, 16, 1'b0);
        // R6: single-pulse alternation
        do_step(1'b1, 2, 1'b1);
        do_step(1'b1, 2, 1'b1);
        do_step(1'b0, 3, 1'b1);
        do_step(1'b0, 5, 1'b0);
        // R8: queue one step, drop a third
        w0 = wn; c0 = cyc;
        step = 1'b1; dir = 1'b1; stride = 6'd4; single = 1'b0;
        @(negedge clk); step = 1'b0;
        @(negedge clk); step = 1'b1; dir = 1'b0;
        @(negedge clk); dir = 1'b1;
        @(negedge clk); step = 1'b0;
        wait_idle();
        chk(wn - w0 == 4, "R8 queued count, extra dropped", wn - w0, 4);
        pos_m = (pos_m + 4) % 64;
        chk(int'(log_d[w0]) == exp_word(0, pos_m), "R8 first sequence", int'(log_d[w0]), exp_word(0, pos_m));
        pos_m = (pos_m + 60) % 64;
        chk(int'(log_d[w0+2]) == exp_word(0, pos_m) && int'(log_d[w0+3]) == exp_word(1, pos_m),
            "R8 queued direction", int'(log_d[w0+3]), exp_word(1, pos_m));
        chk(log_t[w0+2] == c0 + 8, "R8 queued timing", log_t[w0+2] - c0, 8);
        alt_m = 0;
        // Random steps
        for (int i = 0; i < 200; i++) begin
            sel = int'($urandom % 6);
            case (sel)
                0: s = 1; 1: s = 2; 2: s = 4; 3: s = 8; 4: s = 16;
                default: s = 1 + int'($urandom % 31);
            endcase
            do_step(1'($urandom % 2), s, 1'($urandom % 2));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule